// File: doc/BRIEF.md
# Priority Bus Arbiter with Burst Lock

This block decides which of four masters owns a shared external memory bus: an off-chip bus master (bus release), the refresh logic, the DMA controller and the CPU. Only one owner holds the bus at a time. Ownership follows a fixed priority. An owner keeps the bus until it withdraws its request. One idle cycle always separates two owners.

A small control register sets three things. The first is whether off-chip requests take part in arbitration. The second is whether an in-progress DMA burst locks out even the higher-priority bus-release and refresh requests. The third is whether the address and strobe pins stay driven during software standby. The block also produces a single output enable for the address, bus-strobe, chip-select and read/write pin group. That enable goes low while the bus is released to the off-chip master, and in standby it follows the drive bit.

All interfaces are plain control pins. No data stream flows through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `bus_arbiter_top`

## Requirements
- R1: After reset no grant is active, `ctrl_rdata` reads 0, and `gnt` is never more than one-hot. The bit positions are: bit0 off-chip, bit1 refresh, bit2 DMA, bit3 CPU.
- R2: With burst lock off, an idle arbiter grants the highest eligible requester. The order from highest to lowest is off-chip, refresh, DMA, CPU.
- R3: A granted off-chip, refresh or DMA master keeps its grant until its request is sampled low. The grant then drops for at least one cycle before any other grant rises.
- R4: The CPU is granted from idle when no other request is eligible. While the CPU is granted, any eligible request makes the CPU grant drop.
- R5: When control bit0 (off-chip enable) is 0, `req_ext` is ignored by arbitration. When bit0 is 1, `req_ext` takes part.
- R6: With control bit1 (burst lock) set, a DMA burst starts when `dma_burst` is sampled high while DMA holds the grant. The burst ends when `dma_burst` is sampled low while DMA holds the grant. Between those points, off-chip and refresh requests are not granted.
- R7: While the off-chip master holds the grant, `pin_oe` is 0, whatever the other inputs are.
- R8: When the bus is not released, `pin_oe` is 1 outside standby. In standby (`standby`=1), `pin_oe` equals control bit2 (pin drive).
- R9: Control bits 0..2 are written by `ctrl_we` with `ctrl_wdata` on a clock edge and read combinationally on `ctrl_rdata`. Bit3 is reserved: it always reads 0, and writes to it are ignored.
- R10: With burst lock off, an active DMA burst does not hold off off-chip or refresh requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| req_ext | input | 1 | Off-chip bus request |
| req_ref | input | 1 | Refresh request |
| req_dma | input | 1 | DMA request |
| dma_burst | input | 1 | DMA burst-mode transfer in progress |
| standby | input | 1 | Software standby state |
| ctrl_we | input | 1 | Control register write enable |
| ctrl_wdata | input | 4 | Control register write data |
| ctrl_rdata | output | 4 | Control register read data |
| gnt | output | 4 | One-hot grant {cpu, dma, refresh, off-chip} |
| pin_oe | output | 1 | Output enable for address/strobe/select/direction pins |

## Verification
The bench first applies simultaneous requests from every combination of masters, which shows whether the priority order and the idle gap between owners hold. Next it raises requests while the CPU owns the bus, to separate CPU yielding from plain default granting. DMA bursts are then run with the lock bit set and cleared, with refresh and off-chip requests arriving mid-burst and with DMA dropping its request before the burst ends. These runs separate burst tracking from plain request tracking. Finally it sweeps the standby level and the drive bit across owned and released bus states, and writes to the reserved bit.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int N_REQ      = 4;
  localparam int CTRL_W     = 4;
  localparam int CTRL_EXTEN = 0;
  localparam int CTRL_LOCK  = 1;
  localparam int CTRL_DRIVE = 2;
  localparam int GNT_EXT    = 0;
  localparam int GNT_REF    = 1;
  localparam int GNT_DMA    = 2;
  localparam int GNT_CPU    = 3;

  typedef enum logic [2:0] {
    OWN_IDLE = 3'd0,
    OWN_EXT  = 3'd1,
    OWN_REF  = 3'd2,
    OWN_DMA  = 3'd3,
    OWN_CPU  = 3'd4
  } owner_e;
endpackage

// File: rtl/arb_ctrl_reg.sv
module arb_ctrl_reg
  import arb_pkg::*;
#(
  parameter int W = CTRL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         ext_en,
  output logic         lock_en,
  output logic         drive_en
);
  localparam logic [W-1:0] WR_MASK =
    W'((1 << CTRL_EXTEN) | (1 << CTRL_LOCK) | (1 << CTRL_DRIVE));

  logic [W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= '0;
    else if (we) ctrl_q <= wdata & WR_MASK;
  end

  assign rdata    = ctrl_q;
  assign ext_en   = ctrl_q[CTRL_EXTEN];
  assign lock_en  = ctrl_q[CTRL_LOCK];
  assign drive_en = ctrl_q[CTRL_DRIVE];
endmodule

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
  import arb_pkg::*;
#(
  parameter int N = N_REQ
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_ext,
  input  logic         req_ref,
  input  logic         req_dma,
  input  logic         dma_burst,
  input  logic         ext_en,
  input  logic         lock_en,
  output logic [N-1:0] gnt
);
  owner_e owner_q, owner_d;
  logic   burst_q;
  logic   blocked, el_ext, el_ref, el_dma, any_el;

  assign blocked = lock_en && burst_q;
  assign el_ext  = req_ext && ext_en && !blocked;
  assign el_ref  = req_ref && !blocked;
  assign el_dma  = req_dma;
  assign any_el  = el_ext || el_ref || el_dma;

  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      OWN_IDLE: begin
        if      (el_ext) owner_d = OWN_EXT;
        else if (el_ref) owner_d = OWN_REF;
        else if (el_dma) owner_d = OWN_DMA;
        else             owner_d = OWN_CPU;
      end
      OWN_EXT: if (!req_ext) owner_d = OWN_IDLE;
      OWN_REF: if (!req_ref) owner_d = OWN_IDLE;
      OWN_DMA: if (!req_dma) owner_d = OWN_IDLE;
      OWN_CPU: if (any_el)   owner_d = OWN_IDLE;
      default: owner_d = OWN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= OWN_IDLE;
      burst_q <= 1'b0;
    end else begin
      owner_q <= owner_d;
      if (owner_q == OWN_DMA) burst_q <= dma_burst;
    end
  end

  always_comb begin
    gnt = '0;
    gnt[GNT_EXT] = (owner_q == OWN_EXT);
    gnt[GNT_REF] = (owner_q == OWN_REF);
    gnt[GNT_DMA] = (owner_q == OWN_DMA);
    gnt[GNT_CPU] = (owner_q == OWN_CPU);
  end

  // R1
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R3
  gap_between_owners_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |=> (gnt == '0 || gnt == $past(gnt)));
  // R3
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[GNT_EXT] && req_ext) |=> gnt[GNT_EXT]);
  // R6
  burst_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_en && burst_q && owner_q == OWN_IDLE) |=> !(gnt[GNT_EXT] || gnt[GNT_REF]));
endmodule

// File: rtl/arb_pin_ctrl.sv
module arb_pin_ctrl (
  input  logic released,
  input  logic standby,
  input  logic drive_en,
  output logic pin_oe
);
  always_comb begin
    if (released)     pin_oe = 1'b0;
    else if (standby) pin_oe = drive_en;
    else              pin_oe = 1'b1;
  end
endmodule

// File: rtl/bus_arbiter_top.sv
module bus_arbiter_top
  import arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_ext,
  input  logic              req_ref,
  input  logic              req_dma,
  input  logic              dma_burst,
  input  logic              standby,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  output logic [N_REQ-1:0]  gnt,
  output logic              pin_oe
);
  logic ext_en, lock_en, drive_en;

  arb_ctrl_reg #(.W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata),
    .rdata(ctrl_rdata), .ext_en(ext_en), .lock_en(lock_en), .drive_en(drive_en)
  );

  arb_grant_fsm #(.N(N_REQ)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_ext(req_ext), .req_ref(req_ref),
    .req_dma(req_dma), .dma_burst(dma_burst), .ext_en(ext_en),
    .lock_en(lock_en), .gnt(gnt)
  );

  arb_pin_ctrl u_pin (
    .released(gnt[GNT_EXT]), .standby(standby), .drive_en(drive_en),
    .pin_oe(pin_oe)
  );

  // R5
  ext_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en && !gnt[GNT_EXT]) |=> !gnt[GNT_EXT]);
  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_rdata[3] == 1'b0));
endmodule

// File: tb/test_bus_arbiter_top.sv
module test_bus_arbiter_top;
  logic clk = 0;
  logic rst_n = 0;
  logic req_ext = 0, req_ref = 0, req_dma = 0, dma_burst = 0, standby = 0;
  logic ctrl_we = 0;
  logic [3:0] ctrl_wdata = 0;
  logic [3:0] ctrl_rdata;
  logic [3:0] gnt;
  logic pin_oe;

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R1";

  // behavioural model: 0 idle, 1 ext, 2 ref, 3 dma, 4 cpu
  int m_own = 0;
  bit m_pend = 0;
  int m_ctrl = 0;

  always #4 clk = ~clk;

  bus_arbiter_top i_bus_arbiter_top (
    .clk(clk), .rst_n(rst_n), .req_ext(req_ext), .req_ref(req_ref),
    .req_dma(req_dma), .dma_burst(dma_burst), .standby(standby),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .gnt(gnt), .pin_oe(pin_oe)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_own = 0; m_pend = 0; m_ctrl = 0;
    end else begin
      bit blk, e_x, e_r, e_d;
      int nxt;
      blk = m_ctrl[1] && m_pend;
      e_x = req_ext && m_ctrl[0] && !blk;
      e_r = req_ref && !blk;
      e_d = req_dma;
      nxt = m_own;
      if (m_own == 0) nxt = e_x ? 1 : e_r ? 2 : e_d ? 3 : 4;
      else if (m_own == 1 && !req_ext) nxt = 0;
      else if (m_own == 2 && !req_ref) nxt = 0;
      else if (m_own == 3 && !req_dma) nxt = 0;
      else if (m_own == 4 && (e_x || e_r || e_d)) nxt = 0;
      if (m_own == 3) m_pend = dma_burst;
      m_own = nxt;
      if (ctrl_we) m_ctrl = ctrl_wdata & 4'b0111;
    end
  end

  function automatic logic [3:0] exp_gnt();
    return (m_own == 0) ? 4'b0000 : 4'(1 << (m_own - 1));
  endfunction

  function automatic logic exp_oe();
    if (m_own == 1) return 1'b0;
    if (standby) return 1'(m_ctrl[2]);
    return 1'b1;
  endfunction

  task automatic check(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", t, cyc, act, exp);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(gnt == exp_gnt(), {tag, " gnt"}, gnt, exp_gnt());
      check(pin_oe == exp_oe(), {tag, " pin_oe"}, pin_oe, exp_oe());
      check(ctrl_rdata == 4'(m_ctrl), {tag, " rdata"}, ctrl_rdata, m_ctrl);
    end
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] v);
    ctrl_we = 1; ctrl_wdata = v; step(1); ctrl_we = 0;
  endtask

  initial begin
    step(2);
    // R1: reset state
    check(gnt == 4'b0000, "R1 reset gnt", gnt, 0);
    check(ctrl_rdata == 4'b0000, "R1 reset rdata", ctrl_rdata, 0);
    rst_n = 1;
    step(3);
    // R4: CPU by default
    tag = "R4";
    check(gnt == 4'b1000, "R4 cpu default", gnt, 8);
    // R9: reserved bit ignored
    tag = "R9";
    wr(4'b1111);
    check(ctrl_rdata == 4'b0111, "R9 reserved reads 0", ctrl_rdata, 7);
    wr(4'b0001);
    // R2: all requests together, priority
    tag = "R2";
    for (int p = 1; p < 8; p++) begin
      req_ext = p[0]; req_ref = p[1]; req_dma = p[2];
      step(4);
      req_ext = 0; req_ref = 0; req_dma = 0;
      step(4);
    end
    // R3: holding, release order
    tag = "R3";
    req_dma = 1; step(3); req_ref = 1; req_ext = 1; step(5);
    check(gnt == 4'b0100, "R3 dma held", gnt, 4);
    req_dma = 0; step(6); req_ext = 0; step(4); req_ref = 0; step(4);
    // R5: ext disabled
    tag = "R5";
    wr(4'b0000);
    req_ext = 1; step(6);
    check(gnt[0] == 1'b0, "R5 ext ignored", gnt, 8);
    wr(4'b0001); step(4);
    check(gnt == 4'b0001, "R5 ext granted", gnt, 1);
    // R7: released pins
    tag = "R7";
    standby = 1; step(2);
    check(pin_oe == 1'b0, "R7 released oe", pin_oe, 0);
    standby = 0; req_ext = 0; step(4);
    // R8: standby drive sweep
    tag = "R8";
    standby = 1; step(2);
    check(pin_oe == 1'b0, "R8 standby undriven", pin_oe, 0);
    wr(4'b0101); step(1);
    check(pin_oe == 1'b1, "R8 standby driven", pin_oe, 1);
    standby = 0; step(2);
    // R6: burst lock
    tag = "R6";
    wr(4'b0011);
    req_dma = 1; step(3); dma_burst = 1; step(2);
    req_ref = 1; req_ext = 1; step(2);
    req_dma = 0; step(6);   // dma dropped mid-burst: lock holds
    check(gnt[1:0] == 2'b00, "R6 locked out", gnt, 8);
    req_dma = 1; step(4); dma_burst = 0; step(1); req_dma = 0; step(4);
    check(gnt == 4'b0001, "R6 released after burst", gnt, 1);
    req_ext = 0; step(3); req_ref = 0; step(3);
    // R10: lock off, burst does not block
    tag = "R10";
    wr(4'b0001);
    req_dma = 1; step(3); dma_burst = 1; step(2); req_dma = 0; step(2);
    req_ref = 1; step(4);
    check(gnt == 4'b0010, "R10 ref not blocked", gnt, 2);
    req_ref = 0; dma_burst = 0; step(3);
    // mixed pattern sweep
    tag = "R2";
    for (int i = 0; i < 300; i++) begin
      req_ext = ((i * 7) % 5) == 0; req_ref = ((i * 3) % 7) < 2;
      req_dma = ((i * 5) % 9) < 4; dma_burst = ((i * 11) % 6) < 3;
      standby = (i % 13) < 4;
      if (i % 37 == 0) wr(4'((i / 37) % 8) | 4'b1000);
      else step(1);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule